// File: doc/BRIEF.md
# One-Time-Programmable Fuse Bank Controller

This block controls a small array of one-time-programmable fuses: two banks, each 32 rows of 8 bits. Software reaches it through a simple 32-bit register bus. It can start an explicit sense of one fuse row, or burn a single fuse bit. Each bank keeps a shadow cache of its rows. The cache is loaded from the fuse cells at reset, and software may overwrite it with temporary values that last until the next reset.

Row 0 of each bank is that bank's protection word. Its bits, taken from the fuse cells themselves, can forbid four things on that bank: programming, cache overrides, cache reads and sensing. A program cycle needs an unlock key. Every refused access sets its own sticky error bit. The error bits are cleared by writing ones to them.

The fuse cells are a behavioural array inside the block. They keep their contents through a reset. Each sense or program cycle keeps the controller busy for `PULSE_CYCLES` clocks.

Top module: `efuse_ctrl`

Register word addresses: 0x00 status, 0x01 error, 0x02 command (reads 0), 0x03 upper address, 0x04 lower address, 0x05 sense data (read-only), 0x06 unlock key. Cache words: 0x40 + row for bank 0 and 0x60 + row for bank 1. Reads return data combinationally, and their side effects take place on the clock edge while `bus_rd` is high.

## Requirements
- R1: After reset, status and error read 0. Every cache word holds the current value of its fuse row, and row bits that were burned before the reset show up in the cache.
- R2: Writing the command register with bit 3 set starts a sense of the row selected by upper-address bit 3 (bank) and lower-address bits 7:3 (row). Status bit 7 (busy) is then high for exactly `PULSE_CYCLES` clocks. After that, status bit 0 is set and the sense-data register holds the row's 8 fuse bits.
- R3: With the key register at 0xAA, writing the command register with bits 0 and 5 both set burns the fuse bit selected by lower-address bits 2:0. When the cycle ends, status bit 1 is set. A later sense shows the bit. The cache keeps its old value until the next reset.
- R4: A program request while the key is not 0xAA sets error bit 6. It does not set busy or status bit 1, and it leaves the fuse cells unchanged.
- R5: A program request on a bank whose protection word bit 7 is burned sets error bit 6 and leaves the fuse cells unchanged.
- R6: A command write with bit 0 set but bit 5 clear starts nothing.
- R7: A write to a cache word replaces that cache entry. It does not change the fuse cells, and the next reset restores the fuse value.
- R8: A cache write on a bank whose protection bit 6 is burned sets error bit 5 and leaves the entry unchanged.
- R9: A cache read on a bank whose protection bit 5 is burned returns 0 and sets error bit 4.
- R10: A sense request on a bank whose protection bit 3 is burned sets error bit 2. Sense data and status bit 0 stay unchanged.
- R11: A write to the command, address or key register while busy is ignored and sets error bit 3.
- R12: Writing the error register clears exactly the bits written as 1. Writing 0 to the status register clears status bits 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The fuse image at power-up differs between the two banks, so reading the cache and sensing distinct rows shows that each reaches its own bank and row. The program tests use a good key, a wrong key and a pulse bit left out. Each outcome is then observed two ways: through a sense, which reads the fuse cells, and through the cache, before and after a reset. Together these separate burning a bit from updating the shadow cache. Protection bits are burned one at a time into row 0 of a bank, in an order that leaves each later effect still observable, so every refused access is checked both for its own error bit and for its lack of effect.

// File: rtl/efuse_pkg.sv
// Shared constants for the fuse bank controller: register word addresses,
// field bit positions and the sequencer operation type.
package efuse_pkg;
    localparam int REG_STATUS = 'h00;
    localparam int REG_ERROR  = 'h01;
    localparam int REG_CMD    = 'h02;
    localparam int REG_UPPER  = 'h03;
    localparam int REG_LOWER  = 'h04;
    localparam int REG_SDATA  = 'h05;
    localparam int REG_KEY    = 'h06;

    localparam int ST_BUSY = 7;
    localparam int ST_PGD  = 1;
    localparam int ST_SND  = 0;

    localparam int ER_WPROT = 6;
    localparam int ER_OPROT = 5;
    localparam int ER_RPROT = 4;
    localparam int ER_LOCK  = 3;
    localparam int ER_SENSE = 2;

    localparam int CM_PROG  = 0;
    localparam int CM_SENSE = 3;
    localparam int CM_PULSE = 5;

    localparam int PW_WRITE = 7;
    localparam int PW_OVR   = 6;
    localparam int PW_READ  = 5;
    localparam int PW_SENSE = 3;

    localparam logic [7:0] UNLOCK_KEY = 8'hAA;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_SENSE = 2'd1,
        OP_PROG  = 2'd2
    } fuse_op_e;
endpackage

// File: rtl/efuse_cells.sv
// Behavioural fuse array and its cycle sequencer.
// Holds BANKS*ROWS*BITS fuse bits that keep their contents through reset.
// On a start pulse it latches the address and stays busy for PULSE_CYCLES
// clocks. On the last busy clock it either reports the sensed row or burns
// one bit. Assumes BANKS, ROWS and BITS are powers of two, and that the
// caller never pulses a start while busy.
module efuse_cells #(
    parameter int BANKS        = 2,
    parameter int ROWS         = 32,
    parameter int BITS         = 8,
    parameter int PULSE_CYCLES = 16,
    parameter logic [BANKS*ROWS*BITS-1:0] FUSE_INIT = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_sense,
    input  logic                       start_prog,
    input  logic [$clog2(BANKS)-1:0]   req_bank,
    input  logic [$clog2(ROWS)-1:0]    req_row,
    input  logic [$clog2(BITS)-1:0]    req_bit,
    output logic                       busy,
    output logic                       sense_done,
    output logic                       prog_done,
    output logic [BITS-1:0]            sense_val,
    output logic [BANKS*BITS-1:0]      prot_words,
    output logic [BANKS*ROWS*BITS-1:0] cell_image
);
    import efuse_pkg::*;

    localparam int BW    = $clog2(BANKS);
    localparam int RW    = $clog2(ROWS);
    localparam int BIW   = $clog2(BITS);
    localparam int IW    = BW + RW + BIW;
    localparam int CW    = $clog2(PULSE_CYCLES + 1);
    localparam int TOTAL = BANKS * ROWS * BITS;

    logic [TOTAL-1:0] cells = FUSE_INIT;
    fuse_op_e         op_q;
    logic [CW-1:0]    cnt_q;
    logic [BW-1:0]    bank_q;
    logic [RW-1:0]    row_q;
    logic [BIW-1:0]   bit_q;
    logic             finishing;
    logic [IW-1:0]    bit_index;
    logic [IW-1:0]    row_base;

    assign busy       = (op_q != OP_IDLE);
    assign finishing  = busy && (cnt_q == '0);
    assign sense_done = finishing && (op_q == OP_SENSE);
    assign prog_done  = finishing && (op_q == OP_PROG);
    assign bit_index  = {bank_q, row_q, bit_q};
    assign row_base   = {bank_q, row_q, {BIW{1'b0}}};
    assign sense_val  = cells[row_base +: BITS];
    assign cell_image = cells;

    // Protection word of each bank is row 0 of that bank's fuse cells.
    for (genvar b = 0; b < BANKS; b++) begin : g_prot
        assign prot_words[b*BITS +: BITS] = cells[b*ROWS*BITS +: BITS];
    end

    // Sequencer: latch the request, count down the pulse window, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            cnt_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            bit_q  <= '0;
        end else if (busy) begin
            if (cnt_q == '0) op_q <= OP_IDLE;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start_prog || start_sense) begin
            op_q   <= start_prog ? OP_PROG : OP_SENSE;
            cnt_q  <= CW'(PULSE_CYCLES - 1);
            bank_q <= req_bank;
            row_q  <= req_row;
            bit_q  <= req_bit;
        end
    end

    // Burn the addressed bit at the end of a program window; no reset, fuses persist.
    always_ff @(posedge clk) begin
        if (prog_done) cells[bit_index] <= 1'b1;
    end

    // R3: a burned fuse never returns to 0.
    a_r3_fuses_only_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cells & $past(cells)) == $past(cells)));

    // R11: the register front end never starts a cycle while one runs.
    a_r11_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_sense || start_prog));
endmodule

// File: rtl/efuse_cache.sv
// Shadow cache of every fuse row. On reset each entry copies its fuse row
// from the cell image. Afterwards software may override single entries.
// Reads are combinational. Protection checks are left to the caller.
module efuse_cache #(
    parameter int BANKS = 2,
    parameter int ROWS  = 32,
    parameter int BITS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BANKS*ROWS*BITS-1:0] load_image,
    input  logic                       wr_en,
    input  logic [$clog2(BANKS)-1:0]   wr_bank,
    input  logic [$clog2(ROWS)-1:0]    wr_row,
    input  logic [BITS-1:0]            wr_data,
    input  logic [$clog2(BANKS)-1:0]   rd_bank,
    input  logic [$clog2(ROWS)-1:0]    rd_row,
    output logic [BITS-1:0]            rd_data
);
    localparam int BW      = $clog2(BANKS);
    localparam int RW      = $clog2(ROWS);
    localparam int EW      = BW + RW;
    localparam int ENTRIES = BANKS * ROWS;

    logic [BITS-1:0] rows_q [ENTRIES];
    logic [EW-1:0]   wr_sel;

    assign wr_sel  = {wr_bank, wr_row};
    assign rd_data = rows_q[{rd_bank, rd_row}];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // One entry: reload from fuses on reset, else take an override write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rows_q[e] <= load_image[e*BITS +: BITS];
            else if (wr_en && (wr_sel == EW'(e)))
                rows_q[e] <= wr_data;
        end
    end
endmodule

// File: rtl/efuse_ctrl.sv
// Register front end of the fuse bank controller. Decodes the bus,
// checks the unlock key and the per-bank protection words, and raises
// sticky error bits that are cleared by writing ones. It starts sense and
// program cycles in efuse_cells and serves cache reads and overrides
// through efuse_cache.
// Assumes BITS = 8 (the field positions are byte-wide) and that the cache
// region, at word address 1 << (row bits + bank bits), fits in AW bits.
module efuse_ctrl #(
    parameter int BANKS        = 2,
    parameter int ROWS         = 32,
    parameter int BITS         = 8,
    parameter int PULSE_CYCLES = 16,
    parameter int AW           = 8,
    parameter logic [BANKS*ROWS*BITS-1:0] FUSE_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata
);
    import efuse_pkg::*;

    localparam int BW  = $clog2(BANKS);
    localparam int RW  = $clog2(ROWS);
    localparam int BIW = $clog2(BITS);
    localparam int HW  = AW - RW - BW;
    localparam logic [AW-1:0] A_STATUS = AW'(REG_STATUS);
    localparam logic [AW-1:0] A_ERROR  = AW'(REG_ERROR);
    localparam logic [AW-1:0] A_CMD    = AW'(REG_CMD);
    localparam logic [AW-1:0] A_UPPER  = AW'(REG_UPPER);
    localparam logic [AW-1:0] A_LOWER  = AW'(REG_LOWER);
    localparam logic [AW-1:0] A_SDATA  = AW'(REG_SDATA);
    localparam logic [AW-1:0] A_KEY    = AW'(REG_KEY);

    logic                       busy, sense_done, prog_done;
    logic [BITS-1:0]            sense_val, cache_rd;
    logic [BANKS*BITS-1:0]      prot_words;
    logic [BANKS*ROWS*BITS-1:0] cell_image;
    logic [BITS-1:0]            prot_arr [BANKS];

    logic          pgd_q, snd_q;
    logic [7:0]    err_q, err_set, err_clr;
    logic [7:0]    upper_q, lower_q, key_q;
    logic [BITS-1:0] sdat_q;

    logic          is_cache;
    logic [BW-1:0] c_bank, u_bank;
    logic [RW-1:0] c_row;
    logic          wr_cmd, wr_lockable, lock_hit;
    logic          prog_req, prog_go, sense_req, sense_go;
    logic          cache_wr_go, cache_wr_bad, cache_rd_bad;
    logic [BITS-1:0] u_prot, c_prot;
    logic          unused_bits;

    for (genvar b = 0; b < BANKS; b++) begin : g_prot_unpack
        assign prot_arr[b] = prot_words[b*BITS +: BITS];
    end

    // Bus address and request decode, including key and protection checks.
    always_comb begin
        is_cache    = (bus_addr[AW-1:RW+BW] == HW'(1));
        c_bank      = bus_addr[RW +: BW];
        c_row       = bus_addr[RW-1:0];
        u_bank      = upper_q[3 +: BW];
        u_prot      = prot_arr[u_bank];
        c_prot      = prot_arr[c_bank];
        wr_cmd      = bus_wr && (bus_addr == A_CMD);
        wr_lockable = bus_wr && ((bus_addr == A_CMD) || (bus_addr == A_UPPER) ||
                                 (bus_addr == A_LOWER) || (bus_addr == A_KEY));
        lock_hit    = wr_lockable && busy;
        prog_req    = wr_cmd && !busy && bus_wdata[CM_PROG] && bus_wdata[CM_PULSE];
        prog_go     = prog_req && (key_q == UNLOCK_KEY) && !u_prot[PW_WRITE];
        sense_req   = wr_cmd && !busy && !prog_req && bus_wdata[CM_SENSE];
        sense_go    = sense_req && !u_prot[PW_SENSE];
        cache_wr_go  = bus_wr && is_cache && !c_prot[PW_OVR];
        cache_wr_bad = bus_wr && is_cache && c_prot[PW_OVR];
        cache_rd_bad = bus_rd && is_cache && c_prot[PW_READ];
    end

    // Gather the error bits raised and cleared in this cycle.
    always_comb begin
        err_set = '0;
        err_set[ER_WPROT] = prog_req && !prog_go;
        err_set[ER_OPROT] = cache_wr_bad;
        err_set[ER_RPROT] = cache_rd_bad;
        err_set[ER_LOCK]  = lock_hit;
        err_set[ER_SENSE] = sense_req && !sense_go;
        err_clr = (bus_wr && (bus_addr == A_ERROR)) ? bus_wdata[7:0] : 8'h00;
    end

    efuse_cells #(
        .BANKS(BANKS), .ROWS(ROWS), .BITS(BITS),
        .PULSE_CYCLES(PULSE_CYCLES), .FUSE_INIT(FUSE_INIT)
    ) cells_i (
        .clk(clk), .rst_n(rst_n),
        .start_sense(sense_go), .start_prog(prog_go),
        .req_bank(u_bank), .req_row(lower_q[3 +: RW]), .req_bit(lower_q[BIW-1:0]),
        .busy(busy), .sense_done(sense_done), .prog_done(prog_done),
        .sense_val(sense_val), .prot_words(prot_words), .cell_image(cell_image)
    );

    efuse_cache #(.BANKS(BANKS), .ROWS(ROWS), .BITS(BITS)) cache_i (
        .clk(clk), .rst_n(rst_n), .load_image(cell_image),
        .wr_en(cache_wr_go), .wr_bank(c_bank), .wr_row(c_row),
        .wr_data(bus_wdata[BITS-1:0]),
        .rd_bank(c_bank), .rd_row(c_row), .rd_data(cache_rd)
    );

    // Sticky error register: sets win over same-cycle write-one clears.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    // Completion flags: set by the sequencer, cleared by writing 0 to status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgd_q <= 1'b0;
            snd_q <= 1'b0;
        end else begin
            if (prog_done) pgd_q <= 1'b1;
            else if (bus_wr && bus_addr == A_STATUS && !bus_wdata[ST_PGD]) pgd_q <= 1'b0;
            if (sense_done) snd_q <= 1'b1;
            else if (bus_wr && bus_addr == A_STATUS && !bus_wdata[ST_SND]) snd_q <= 1'b0;
        end
    end

    // Address, key and sense-data holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
            key_q   <= '0;
            sdat_q  <= '0;
        end else begin
            if (bus_wr && !busy && bus_addr == A_UPPER) upper_q <= bus_wdata[7:0];
            if (bus_wr && !busy && bus_addr == A_LOWER) lower_q <= bus_wdata[7:0];
            if (bus_wr && !busy && bus_addr == A_KEY)   key_q   <= bus_wdata[7:0];
            if (sense_done) sdat_q <= sense_val;
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (is_cache) begin
            if (!c_prot[PW_READ]) bus_rdata = 32'(cache_rd);
        end else begin
            case (bus_addr)
                A_STATUS: bus_rdata = 32'({busy, 5'b0, pgd_q, snd_q});
                A_ERROR:  bus_rdata = 32'(err_q);
                A_UPPER:  bus_rdata = 32'(upper_q);
                A_LOWER:  bus_rdata = 32'(lower_q);
                A_SDATA:  bus_rdata = 32'(sdat_q);
                A_KEY:    bus_rdata = 32'(key_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{bus_wdata[31:8]};

    // R4: a refused program request never opens a program window.
    a_r4_refused_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[ER_WPROT]) |-> !busy);

    // R10: sense data changes only at the end of a sense window.
    a_r10_sdat_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sense_done) |-> $stable(sdat_q));

    // R2: the sense-done flag rises only as a busy window ends.
    a_r2_snd_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snd_q) |-> $past(busy));

    // R3: the program-done flag rises only as a busy window ends.
    a_r3_pgd_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgd_q) |-> $past(busy));
endmodule

// File: tb/efuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module efuse_ctrl_tb_top;
    localparam int PC = 4;
    localparam logic [511:0] INIT = (512'h81 << 56) | (512'hA5 << 280);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_checks = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    efuse_ctrl #(.PULSE_CYCLES(PC), .FUSE_INIT(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 50; i++) begin
            rd(8'h00, v);
            if (!v[7]) break;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [7:0] up, input logic [7:0] lo, input logic [31:0] cmd);
        wr(8'h03, {24'b0, up});
        wr(8'h04, {24'b0, lo});
        wr(8'h02, cmd);
        wait_idle();
    endtask

    task automatic t_reset_state();
        expect_reg("R1 status after reset", 8'h00, 32'h0);
        expect_reg("R1 error after reset", 8'h01, 32'h0);
        expect_reg("R1 cache bank1 row3", 8'h63, 32'hA5);
        expect_reg("R1 cache bank0 row7", 8'h47, 32'h81);
    endtask

    task automatic t_sense_timing();
        logic [31:0] v;
        wr(8'h03, 32'h00);
        wr(8'h04, 32'h38);
        wr(8'h02, 32'h08);
        rd(8'h00, v); check("R2 busy right after start", v, 32'h80);
        repeat (PC - 2) @(negedge clk);
        rd(8'h00, v); check("R2 busy on last window cycle", v, 32'h80);
        rd(8'h00, v); check("R2 idle with sense done", v, 32'h01);
        expect_reg("R2 sense data bank0 row7", 8'h05, 32'h81);
        issue(8'h08, 8'h18, 32'h08);
        expect_reg("R2 sense data bank1 row3", 8'h05, 32'hA5);
        wr(8'h00, 32'h0);
        expect_reg("R12 status cleared by zero write", 8'h00, 32'h0);
    endtask

    task automatic t_prog_bad_key();
        wr(8'h06, 32'h55);
        issue(8'h00, 8'h14, 32'h21);
        expect_reg("R4 wrong key sets write-protect error", 8'h01, 32'h40);
        expect_reg("R4 no program done", 8'h00, 32'h0);
        issue(8'h00, 8'h10, 32'h08);
        expect_reg("R4 fuse row2 unchanged", 8'h05, 32'h00);
        wr(8'h00, 32'h0);
        wr(8'h01, 32'h20);
        expect_reg("R12 clearing other bit keeps error", 8'h01, 32'h40);
        wr(8'h01, 32'h40);
        expect_reg("R12 write-one clears error", 8'h01, 32'h0);
    endtask

    task automatic t_prog_no_pulse();
        logic [31:0] v;
        wr(8'h06, 32'hAA);
        wr(8'h03, 32'h00);
        wr(8'h04, 32'h14);
        wr(8'h02, 32'h01);
        rd(8'h00, v); check("R6 no busy without pulse bit", v, 32'h0);
        repeat (PC + 2) @(negedge clk);
        expect_reg("R6 still no program done", 8'h00, 32'h0);
    endtask

    task automatic t_prog_ok();
        issue(8'h00, 8'h14, 32'h21);
        expect_reg("R3 program done flag", 8'h00, 32'h02);
        expect_reg("R3 no error", 8'h01, 32'h0);
        issue(8'h00, 8'h10, 32'h08);
        expect_reg("R3 sensed burned bit", 8'h05, 32'h10);
        expect_reg("R3 cache not yet updated", 8'h42, 32'h00);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_override();
        wr(8'h49, 32'h3C);
        expect_reg("R7 override readback", 8'h49, 32'h3C);
        issue(8'h00, 8'h48, 32'h08);
        expect_reg("R7 fuse cells untouched", 8'h05, 32'h00);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_locked();
        wr(8'h03, 32'h00);
        wr(8'h04, 32'h38);
        wr(8'h02, 32'h08);
        wr(8'h03, 32'h08);
        wait_idle();
        expect_reg("R11 locked write raises error", 8'h01, 32'h08);
        expect_reg("R11 upper address kept", 8'h03, 32'h00);
        expect_reg("R11 sense used old address", 8'h05, 32'h81);
        wr(8'h01, 32'h08);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_reset_reload();
        do_reset();
        expect_reg("R1 status after second reset", 8'h00, 32'h0);
        expect_reg("R3 cache shows burned bit after reset", 8'h42, 32'h10);
        expect_reg("R7 override gone after reset", 8'h49, 32'h00);
        expect_reg("R1 key cleared", 8'h06, 32'h00);
    endtask

    task automatic t_protections();
        wr(8'h06, 32'hAA);
        issue(8'h00, 8'h10, 32'h08);
        issue(8'h08, 8'h03, 32'h21);
        wr(8'h00, 32'h0);
        issue(8'h08, 8'h18, 32'h08);
        expect_reg("R10 sense-protect error", 8'h01, 32'h04);
        expect_reg("R10 sense data unchanged", 8'h05, 32'h10);
        expect_reg("R10 no sense done", 8'h00, 32'h0);
        wr(8'h01, 32'h04);
        issue(8'h08, 8'h06, 32'h21);
        wr(8'h00, 32'h0);
        wr(8'h64, 32'h77);
        expect_reg("R8 override-protect error", 8'h01, 32'h20);
        expect_reg("R8 cache entry unchanged", 8'h64, 32'h00);
        wr(8'h01, 32'h20);
        issue(8'h08, 8'h05, 32'h21);
        wr(8'h00, 32'h0);
        expect_reg("R9 read-protected returns zero", 8'h63, 32'h00);
        expect_reg("R9 read-protect error", 8'h01, 32'h10);
        wr(8'h01, 32'h10);
        expect_reg("R9 bank0 still readable", 8'h47, 32'h81);
        issue(8'h00, 8'h07, 32'h21);
        wr(8'h00, 32'h0);
        issue(8'h00, 8'h58, 32'h21);
        expect_reg("R5 write-protect error", 8'h01, 32'h40);
        expect_reg("R5 no program done", 8'h00, 32'h0);
        issue(8'h00, 8'h58, 32'h08);
        expect_reg("R5 fuse row11 unchanged", 8'h05, 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_sense_timing();
        t_prog_bad_key();
        t_prog_no_pulse();
        t_prog_ok();
        t_override();
        t_locked();
        t_reset_reload();
        t_protections();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end
endmodule